// File: doc/BRIEF.md
# Windowed Watchdog Reset Timer

This block is a watchdog downcounter that software has to reload inside a permitted time window. It is advanced by a tick from a fixed prescaler on the CPU clock. Two registers control it. The control register holds an enable bit and a 7-bit count. The window register holds the upper limit on the count at which a reload is allowed. Once the watchdog is running, only a reset can stop it. Two faults produce a one-cycle system reset request: the count runs out with no reload, or software reloads the count too early, while it is still above the window value.

The control FSM has three states. `ST_IDLE` means disabled and not counting. `ST_RUN` means enabled and counting down. `ST_FIRE` is the single cycle in which the reset request is driven. The transitions are:

- `IDLE→RUN` on a control write with enable set and count bit 6 set.
- `IDLE→FIRE` on a control write with enable set and count bit 6 clear.
- `RUN→FIRE` on a timeout, on an early reload, or on a reload with bit 6 clear.
- `RUN→RUN` on a legal reload or a decrement.
- `FIRE→IDLE` unconditionally. This transition restores the power-on values.

With the default prescaler of 12288 clocks and a 16 MHz clock, one count step takes about 0.77 ms. The 64 usable steps give roughly 49 ms. The prescaler is a parameter so that other timeout ranges can be reached.

Top module: `win_watchdog`

## Requirements
- R1: After reset the count reads 0x7F, the window reads 0x7F, `armed` is 0 and `rst_req` is 0.
- R2: While enabled, the count drops by one every PRESCALE clocks. The first drop comes PRESCALE clocks after the enabling write. While disabled, the count holds unless it is written.
- R3: When a tick arrives at count 0x40 with no reload in that cycle, `rst_req` rises on the next clock. An enable with starting count C therefore fires after (C−63)·PRESCALE clocks.
- R4: A reload while enabled is too early, and fires `rst_req` on the next clock, when the count exceeds the window value. A reload with the count at or below the window value loads the new count.
- R5: A control write that leaves the watchdog enabled with count bit 6 (bit 6 of the write data) clear fires `rst_req` on the next clock. This applies both when enabling and when reloading.
- R6: In the control write data, bit 7 is enable and bits 6:0 are the count. A write with bit 7 clear while enabled does not disable the watchdog.
- R7: `rst_req` is high for exactly one clock. On the following clock the count and the window read 0x7F and `armed` is 0.
- R8: A legal reload in the same cycle as the tick that would expire the count takes priority. No reset occurs, and the count takes the written value.
- R9: While disabled, a control write with bit 7 clear loads the count with no bit-6 check and no request. Window writes are accepted in both idle and running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 7 enable, bits 6:0 count |
| win_we | input | 1 | Window register write strobe |
| win_wdata | input | 7 | Window write data |
| count | output | 7 | Current downcounter value |
| window | output | 7 | Current window value |
| armed | output | 1 | Watchdog enabled and counting |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A reload and the prescaler tick that would expire the count can land on the same clock edge. The bench enables the watchdog with count 0x41 and counts clocks so that a legal reload is presented exactly at the edge where the 0x40 tick falls. It judges the result by seeing no reset request and the count reading the written value on the next clock. A timeout sweep over every starting count and a sweep of count against window cover each side of both conflicts.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W = 7;
    localparam logic [CNT_W-1:0] CNT_TOP    = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_EXPIRE = 7'h40;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdg_state_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PRESCALE = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);
            logic [PC_W-1:0] pc_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             pc_q <= '0;
                else if (!run_i)        pc_q <= '0;
                else if (pc_q == PC_LAST) pc_q <= '0;
                else                    pc_q <= pc_q + 1'b1;
            end

            assign tick_o = run_i && (pc_q == PC_LAST);

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R2
        end else begin : g_pass
            assign tick_o = run_i;
        end
    endgenerate
endmodule

// File: rtl/wdg_window.sv
module wdg_window
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] win_o,
    output logic             too_early_o
);
    logic [CNT_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_q <= CNT_TOP;
        else if (clear_i) win_q <= CNT_TOP;
        else if (we_i)    win_q <= wdata_i;
    end

    assign win_o       = win_q;
    assign too_early_o = (count_i > win_q);

    AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clear_i) |=> (win_o == $past(wdata_i))); // R9
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             too_early_i,
    input  logic             ctrl_we_i,
    input  logic [7:0]       ctrl_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             armed_o,
    output logic             fire_o
);
    wdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             wr_en_bit, wr_b6;

    assign wr_en_bit = ctrl_wdata_i[7];
    assign wr_b6     = ctrl_wdata_i[6];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= CNT_TOP;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_we_i) begin
                    count_d = ctrl_wdata_i[CNT_W-1:0];
                    if (wr_en_bit) state_d = wr_b6 ? ST_RUN : ST_FIRE;
                end
            end
            ST_RUN: begin
                if (ctrl_we_i) begin
                    if (too_early_i || !wr_b6) state_d = ST_FIRE;
                    else                       count_d = ctrl_wdata_i[CNT_W-1:0];
                end else if (tick_i) begin
                    if (count_q == CNT_EXPIRE) state_d = ST_FIRE;
                    else                       count_d = count_q - 1'b1;
                end
            end
            ST_FIRE: begin
                state_d = ST_IDLE;
                count_d = CNT_TOP;
            end
            default: begin
                state_d = ST_IDLE;
                count_d = CNT_TOP;
            end
        endcase
    end

    // outputs
    always_comb begin
        count_o = count_q;
        armed_o = (state_q == ST_RUN);
        fire_o  = (state_q == ST_FIRE);
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o); // R7
    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> (armed_o || fire_o)); // R6
    AST_EARLY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && ctrl_we_i && too_early_i) |=> fire_o); // R4
    AST_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !ctrl_we_i && tick_i && count_o == CNT_EXPIRE) |=> fire_o); // R3
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !ctrl_we_i) |=> $stable(count_o)); // R2
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int PRESCALE = 12288
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       win_we,
    input  logic [6:0] win_wdata,
    output logic [6:0] count,
    output logic [6:0] window,
    output logic       armed,
    output logic       rst_req
);
    logic tick, too_early, fire, run;

    assign run = armed;

    wdg_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    wdg_window u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (win_we),
        .wdata_i     (win_wdata),
        .clear_i     (fire),
        .count_i     (count),
        .win_o       (window),
        .too_early_o (too_early)
    );

    wdg_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .too_early_i  (too_early),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (ctrl_wdata),
        .count_o      (count),
        .armed_o      (armed),
        .fire_o       (fire)
    );

    assign rst_req = fire;

    AST_POST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (count == CNT_TOP && window == CNT_TOP && !armed)); // R7
    AST_BAD_B6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[7] && !ctrl_wdata[6] && !rst_req) |=> rst_req); // R5
endmodule

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       win_we = 1'b0;
    logic [6:0] win_wdata = '0;
    logic [6:0] count, window;
    logic       armed, rst_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_watchdog #(.PRESCALE(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .win_we(win_we), .win_wdata(win_wdata), .count(count),
        .window(window), .armed(armed), .rst_req(rst_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        ctrl_we = 0; win_we = 0;
        rst_n = 0;
        step();
        rst_n = 1;
        step();
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        ctrl_we = 1; ctrl_wdata = d;
        step();
        ctrl_we = 0;
    endtask

    task automatic wr_win(input logic [6:0] d);
        win_we = 1; win_wdata = d;
        step();
        win_we = 0;
    endtask

    task automatic chk_after_fire(input string tag);
        chk({tag, " pulse"}, int'(rst_req), 1);
        step();
        chk({tag, " one-cycle"}, int'(rst_req), 0);
        chk({tag, " count restore"}, int'(count), 'h7F);
        chk({tag, " window restore"}, int'(window), 'h7F);
        chk({tag, " disarmed"}, int'(armed), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 count", int'(count), 'h7F);
        chk("R1 window", int'(window), 'h7F);
        chk("R1 armed", int'(armed), 0);
        chk("R1 rst_req", int'(rst_req), 0);

        // R2 frozen while disabled
        for (int k = 0; k < 3 * P; k++) step();
        chk("R2 idle hold", int'(count), 'h7F);

        // R9 idle write bit7 clear, bit6 clear: load only, no request
        wr_ctrl(8'h15);
        chk("R9 idle load", int'(count), 'h15);
        chk("R9 idle no req", int'(rst_req), 0);
        chk("R9 idle not armed", int'(armed), 0);
        wr_win(7'h33);
        chk("R9 window idle write", int'(window), 'h33);
        do_reset();

        // R2 decrement cadence
        wr_ctrl(8'hFF);
        for (int k = 1; k <= 5 * P; k++) begin
            step();
            chk("R2 decrement", int'(count), 'h7F - k / P);
        end
        wr_win(7'h50);
        chk("R9 window run write", int'(window), 'h50);
        do_reset();

        // R3/R7 timeout sweep over every legal start count
        for (int c = 'h40; c <= 'h7F; c++) begin
            int n;
            wr_ctrl(8'h80 | 8'(c));
            n = 0;
            while (!rst_req && n < 300 * P) begin
                step();
                n++;
            end
            chk("R3 timeout clocks", n, (c - 'h3F) * P);
            chk_after_fire("R7 timeout");
        end

        // R4 count vs window sweep: enable, reload next clock (before first tick)
        for (int c = 'h40; c <= 'h7F; c++) begin
            for (int w = 0; w < 128; w += 5) begin
                do_reset();
                wr_win(7'(w));
                wr_ctrl(8'h80 | 8'(c));
                wr_ctrl(8'hFF);
                chk("R4 early reload", int'(rst_req), (c > w) ? 1 : 0);
                if (c <= w) chk("R4 legal reload count", int'(count), 'h7F);
            end
        end
        do_reset();

        // R5 bit6 clear on enable
        wr_ctrl(8'h85);
        chk_after_fire("R5 enable b6 clear");
        // R5 bit6 clear on reload inside window
        wr_ctrl(8'hC5);
        wr_ctrl(8'h3F | 8'h80);
        chk_after_fire("R5 reload b6 clear");

        // R6 bit7 clear while running does not disable
        wr_ctrl(8'hC2);
        wr_ctrl(8'h70);
        chk("R6 still armed", int'(armed), 1);
        chk("R6 reload taken", int'(count), 'h70);
        chk("R6 no req", int'(rst_req), 0);
        do_reset();

        // R8 reload on the same edge as the expiring tick
        wr_ctrl(8'hC1);
        for (int k = 1; k < 2 * P; k++) step();
        chk("R8 count before", int'(count), 'h40);
        ctrl_we = 1; ctrl_wdata = 8'hC8;
        step();
        ctrl_we = 0;
        chk("R8 no req", int'(rst_req), 0);
        chk("R8 reload wins", int'(count), 'h48);
        chk("R8 armed", int'(armed), 1);
        step();
        chk("R8 no late req", int'(rst_req), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule